// File: doc/BRIEF.md
# Programmable-Flag FIFO with Fall-Through Option

A single-clock FIFO for one 10-bit data channel. Its configuration is captured while the active-low master reset is held: one pin picks the read mode, and a two-bit select picks a default threshold for the almost-empty and almost-full flags. In standard mode the two status outputs are empty and full flags, and a read puts the next word on the output one edge later. In fall-through mode the same outputs mean output-ready and input-ready, and the oldest word is presented on the output without any read request.

After reset the mode pin serves as a serial data line. While a serial enable is high, each clock shifts one bit into the threshold registers, so software can replace the defaults. An echo strobe pulses for one cycle each time a read places a fresh word on the output. All flags are registered.

Top module: `pflag_fifo`

## Requirements
- R1: While rst_ni is low the FIFO is emptied. After release, almost_empty_o=1, almost_full_o=0 and echo_ren_o=0. In standard mode empty_or_o=1 and full_ir_o=0. In fall-through mode empty_or_o=0 and full_ir_o=1.
- R2: The read mode is taken from mode_sdi_i at each clock edge while rst_ni is low: 1 selects fall-through and 0 selects standard. Toggling mode_sdi_i after reset does not change the mode.
- R3: fsel_i is sampled at reset and loads both thresholds with the same default: 2'b00 gives 7, 2'b01 gives 63, 2'b10 gives 127 and 2'b11 gives 1023.
- R4: After reset, each clock edge with ser_we_i=1 shifts mode_sdi_i into the thresholds, least significant bit first. The first AW bits form the almost-empty threshold and the next AW bits form the almost-full threshold (AW=11 by default).
- R5: almost_empty_o is 1 exactly when the stored word count is at or below the almost-empty threshold. It is updated at the edge that changes the count.
- R6: almost_full_o is 1 exactly when DEPTH minus the count is at or below the almost-full threshold. It is updated at the edge that changes the count.
- R7: In standard mode, empty_or_o is high at count 0 and full_ir_o is high at count DEPTH. An accepted read drives the oldest word on rd_data_o after the same edge. Words leave in write order.
- R8: In fall-through mode, a word written into an empty FIFO appears on rd_data_o with empty_or_o=1 after the second edge following the write, with no read request. The word and the flag hold until it is read. full_ir_o is the inverse of full.
- R9: echo_ren_o is high for the one cycle after an edge where a read was accepted and a new word was loaded onto rd_data_o. In fall-through mode, reading the last word gives no echo.
- R10: A write when full and a read when empty are ignored: no word is stored, rd_data_o is unchanged and no echo is produced.
- R11: In fall-through mode the count used for the flags includes the word being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low master reset; configuration is sampled while low |
| mode_sdi_i | input | 1 | Read mode during reset, serial threshold data afterwards |
| fsel_i | input | 2 | Default threshold select, sampled during reset |
| ser_we_i | input | 1 | Serial threshold shift enable |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DW | Output word |
| empty_or_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| full_ir_o | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_empty_o | output | 1 | Count at or below almost-empty threshold |
| almost_full_o | output | 1 | Free space at or below almost-full threshold |
| echo_ren_o | output | 1 | One-cycle strobe for each read-loaded word |

## Verification
The assertions check several properties on every cycle:
- the count never exceeds DEPTH, and it does not change on a blocked write;
- the mode holds after reset, and the thresholds hold while the serial enable is low;
- empty implies almost-empty, and full implies almost-full;
- echo follows a read, and no echo follows a read while empty;
- a presented word stays stable until it is read.

The scenarios are needed to show the rest:
- the default-threshold table and the boundary counts where each almost flag toggles;
- the bit order of the serial load;
- the two-edge fall-through latency;
- that a word written while full is really lost.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;

  function automatic int unsigned default_offset(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7;
      2'b01:   return 63;
      2'b10:   return 127;
      default: return 1023;
    endcase
  endfunction
endpackage

// File: rtl/pflag_fifo_cfg.sv
module pflag_fifo_cfg
  import pflag_fifo_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_sdi_i,
  input  logic [1:0]    fsel_i,
  input  logic          ser_we_i,
  output rd_mode_e      mode_o,
  output logic [AW-1:0] ae_off_o,
  output logic [AW-1:0] af_off_o
);
  localparam int SW = 2 * AW;

  rd_mode_e      mode_q;
  logic [SW-1:0] sh_q;
  logic [AW-1:0] def_off;

  assign def_off = AW'(default_offset(fsel_i));

  // sampled on every edge while reset is held; serial path afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= rd_mode_e'(mode_sdi_i);
      sh_q   <= {def_off, def_off};
    end else if (ser_we_i) begin
      sh_q   <= {mode_sdi_i, sh_q[SW-1:1]};
    end
  end

  assign mode_o   = mode_q;
  assign ae_off_o = sh_q[AW-1:0];
  assign af_off_o = sh_q[SW-1:AW];

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_q));
  // R4
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(ser_we_i)) |-> $stable(sh_q));
endmodule

// File: rtl/pflag_fifo_store.sv
module pflag_fifo_store #(
  parameter int DW    = 10,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] cnt_n_o,
  output logic          ov_o,
  output logic          echo_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, ram_cnt;
  logic          ov_q, ov_n;
  logic          full_now, wr_acc, rd_acc, ram_has, ram_rd;

  assign full_now = (cnt_q == CW'(DEPTH));
  assign wr_acc   = wr_en_i && !full_now;
  assign rd_acc   = rd_en_i && (fwft_i ? ov_q : (cnt_q != '0));
  assign ram_cnt  = cnt_q - CW'(ov_q);
  assign ram_has  = (ram_cnt != '0);
  // fall-through refills the output stage whenever it is empty or being drained
  assign ram_rd   = fwft_i ? (ram_has && (!ov_q || rd_acc)) : rd_acc;
  assign cnt_n_o  = cnt_q + CW'(wr_acc) - CW'(rd_acc);

  always_comb begin
    ov_n = 1'b0;
    if (fwft_i) begin
      if (ram_rd)      ov_n = 1'b1;
      else if (rd_acc) ov_n = 1'b0;
      else             ov_n = ov_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_acc) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      ov_q      <= 1'b0;
      rd_data_o <= '0;
      echo_o    <= 1'b0;
    end else begin
      cnt_q  <= cnt_n_o;
      ov_q   <= ov_n;
      echo_o <= rd_acc && ram_rd;
      if (wr_acc) wptr_q <= wptr_q + 1'b1;
      if (ram_rd) begin
        rptr_q    <= rptr_q + 1'b1;
        rd_data_o <= mem[rptr_q];
      end
    end
  end

  assign ov_o = ov_q;

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_now && wr_en_i && !rd_en_i) |=> (cnt_q == CW'(DEPTH)));
  // R8
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && ov_q && !rd_en_i) |=> (ov_q && $stable(rd_data_o)));
endmodule

// File: rtl/pflag_fifo_flags.sv
module pflag_fifo_flags #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_n_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          ae_o,
  output logic          af_o
);
  logic [CW-1:0] free_n;

  assign free_n = CW'(DEPTH) - cnt_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      full_o  <= 1'b0;
      ae_o    <= 1'b1;
      af_o    <= 1'b0;
    end else begin
      empty_o <= (cnt_n_i == '0);
      full_o  <= (cnt_n_i == CW'(DEPTH));
      ae_o    <= (cnt_n_i <= {1'b0, ae_off_i});
      af_o    <= (free_n  <= {1'b0, af_off_i});
    end
  end

  // R5
  empty_ae_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> ae_o);
  // R6
  full_af_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> af_o);
  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int DW    = 10,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_sdi_i,
  input  logic [1:0]    fsel_i,
  input  logic          ser_we_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_or_o,
  output logic          full_ir_o,
  output logic          almost_empty_o,
  output logic          almost_full_o,
  output logic          echo_ren_o
);
  rd_mode_e      mode;
  logic          fwft;
  logic [AW-1:0] ae_off, af_off;
  logic [CW-1:0] cnt_n;
  logic          ov, empty_q, full_q;

  assign fwft = (mode == RD_FWFT);

  pflag_fifo_cfg #(.AW(AW)) u_cfg (
    .clk_i, .rst_ni, .mode_sdi_i, .fsel_i, .ser_we_i,
    .mode_o(mode), .ae_off_o(ae_off), .af_off_o(af_off)
  );

  pflag_fifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk_i, .rst_ni, .fwft_i(fwft), .wr_en_i, .wr_data_i, .rd_en_i,
    .rd_data_o, .cnt_n_o(cnt_n), .ov_o(ov), .echo_o(echo_ren_o)
  );

  pflag_fifo_flags #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_flags (
    .clk_i, .rst_ni, .cnt_n_i(cnt_n), .ae_off_i(ae_off), .af_off_i(af_off),
    .empty_o(empty_q), .full_o(full_q), .ae_o(almost_empty_o), .af_o(almost_full_o)
  );

  assign empty_or_o = fwft ? ov : empty_q;
  assign full_ir_o  = fwft ? !full_q : full_q;

  // R9
  echo_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    echo_ren_o |-> $past(rd_en_i));
  // R10
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft && empty_q && rd_en_i) |=> !echo_ren_o);
  // R11
  ready_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft && ov) |-> !empty_q);
endmodule

// File: tb/pflag_fifo_tb_top.sv
module pflag_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 10;
  localparam int DEPTH = 2048;
  localparam int AW    = 11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_sdi_i = 1'b0;
  logic [1:0]    fsel_i = 2'b00;
  logic          ser_we_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          rd_en_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic          empty_or_o, full_ir_o, almost_empty_o, almost_full_o, echo_ren_o;

  int n_chk = 0, n_fail = 0, mcount = 0, echo_seen = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pflag_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .mode_sdi_i, .fsel_i, .ser_we_i, .wr_en_i, .wr_data_i,
    .rd_en_i, .rd_data_o, .empty_or_o, .full_ir_o, .almost_empty_o,
    .almost_full_o, .echo_ren_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: standard mode, every echo pops the scoreboard
  always @(negedge clk_i) begin
    if (mon_en && echo_ren_o) begin
      echo_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected word", rd_data_o, -1);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data_o == e, "R7 read order", rd_data_o, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic do_reset(input logic m, input logic [1:0] f, input bit mon);
    rst_ni = 1'b0; mode_sdi_i = m; fsel_i = f;
    ser_we_i = 0; wr_en_i = 0; rd_en_i = 0;
    exp_q.delete(); mcount = 0; mon_en = mon;
    step(3);
    rst_ni = 1'b1; mode_sdi_i = 1'b0;
  endtask

  task automatic write_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_en_i = 1'b1; wr_data_i = DW'(base + i);
      if (mcount < DEPTH) begin exp_q.push_back(DW'(base + i)); mcount++; end
      step(1);
    end
    wr_en_i = 1'b0;
  endtask

  task automatic std_read(input int n);
    for (int i = 0; i < n; i++) begin
      rd_en_i = 1'b1;
      if (mcount > 0) mcount--;
      step(1);
    end
    rd_en_i = 1'b0;
  endtask

  task automatic fw_read(input bit exp_echo);
    logic [DW-1:0] e;
    e = exp_q.size() != 0 ? exp_q[0] : '0;
    chk(empty_or_o == 1'b1, "R8 ready before read", empty_or_o, 1);
    chk(rd_data_o == e, "R8 presented word", rd_data_o, e);
    if (exp_q.size() != 0) void'(exp_q.pop_front());
    rd_en_i = 1'b1; mcount--;
    step(1);
    rd_en_i = 1'b0;
    chk(echo_ren_o == exp_echo, "R9 echo after fall-through read", echo_ren_o, exp_echo);
  endtask

  task automatic ser_load(input logic [AW-1:0] ae, input logic [AW-1:0] af);
    for (int i = 0; i < 2*AW; i++) begin
      ser_we_i = 1'b1;
      mode_sdi_i = (i < AW) ? ae[i] : af[i-AW];
      step(1);
    end
    ser_we_i = 1'b0; mode_sdi_i = 1'b0;
    step(1);
  endtask

  initial begin
    logic [DW-1:0] hold;
    int e0;
    // ---------------- standard mode, default 7 ----------------
    do_reset(1'b0, 2'b00, 1'b1);
    chk(empty_or_o == 1, "R1 empty after reset", empty_or_o, 1);
    chk(full_ir_o == 0, "R1 full after reset", full_ir_o, 0);
    chk(almost_empty_o == 1, "R1 almost-empty after reset", almost_empty_o, 1);
    chk(almost_full_o == 0, "R1 almost-full after reset", almost_full_o, 0);
    chk(echo_ren_o == 0, "R1 echo after reset", echo_ren_o, 0);

    hold = rd_data_o;
    std_read(1);
    chk(echo_ren_o == 0, "R10 read when empty gives no echo", echo_ren_o, 0);
    chk(rd_data_o == hold, "R10 read when empty keeps data", rd_data_o, hold);

    write_burst(7, 100);
    chk(empty_or_o == 0, "R7 not empty after writes", empty_or_o, 0);
    chk(almost_empty_o == 1, "R3 R5 count 7 vs default 7", almost_empty_o, 1);
    write_burst(1, 107);
    chk(almost_empty_o == 0, "R5 count 8 above 7", almost_empty_o, 0);

    e0 = echo_seen;
    std_read(8);
    step(1);
    chk(echo_seen - e0 == 8, "R9 one echo per read", echo_seen - e0, 8);
    chk(exp_q.size() == 0, "R7 all words returned", exp_q.size(), 0);
    chk(empty_or_o == 1, "R7 empty after draining", empty_or_o, 1);

    // serial thresholds: almost-empty 2, almost-full 3
    ser_load(11'd2, 11'd3);
    write_burst(2, 200);
    chk(almost_empty_o == 1, "R4 R5 serial threshold 2 at count 2", almost_empty_o, 1);
    write_burst(1, 202);
    chk(almost_empty_o == 0, "R4 R5 count 3 above 2", almost_empty_o, 0);
    write_burst(DEPTH - 7, 203);
    chk(almost_full_o == 0, "R6 free 4 above 3", almost_full_o, 0);
    write_burst(1, 50);
    chk(almost_full_o == 1, "R4 R6 free 3 at threshold", almost_full_o, 1);
    write_burst(3, 51);
    chk(full_ir_o == 1, "R7 full at DEPTH", full_ir_o, 1);
    write_burst(1, 999);
    chk(full_ir_o == 1, "R10 still full after extra write", full_ir_o, 1);

    e0 = echo_seen;
    std_read(DEPTH);
    step(1);
    chk(echo_seen - e0 == DEPTH, "R10 exactly DEPTH words stored", echo_seen - e0, DEPTH);
    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    chk(empty_or_o == 1, "R10 empty after full drain", empty_or_o, 1);
    std_read(1);
    chk(echo_ren_o == 0, "R10 no echo past empty", echo_ren_o, 0);

    // ---------------- default table entries ----------------
    do_reset(1'b0, 2'b01, 1'b0);
    write_burst(63, 0);
    chk(almost_empty_o == 1, "R3 select 01 count 63", almost_empty_o, 1);
    write_burst(1, 63);
    chk(almost_empty_o == 0, "R3 select 01 count 64", almost_empty_o, 0);
    do_reset(1'b0, 2'b10, 1'b0);
    write_burst(127, 0);
    chk(almost_empty_o == 1, "R3 select 10 count 127", almost_empty_o, 1);
    write_burst(1, 127);
    chk(almost_empty_o == 0, "R3 select 10 count 128", almost_empty_o, 0);

    // ---------------- fall-through mode, default 1023 ----------------
    do_reset(1'b1, 2'b11, 1'b0);
    chk(empty_or_o == 0, "R1 output-ready low after reset", empty_or_o, 0);
    chk(full_ir_o == 1, "R1 input-ready high after reset", full_ir_o, 1);
    chk(almost_empty_o == 1, "R1 almost-empty after reset", almost_empty_o, 1);
    // mode pin toggled with the serial enable low
    mode_sdi_i = 1'b0; step(1); mode_sdi_i = 1'b1; step(1); mode_sdi_i = 1'b0; step(1);

    write_burst(1, 300);
    chk(empty_or_o == 0, "R8 not yet presented one edge after write", empty_or_o, 0);
    step(1);
    chk(empty_or_o == 1, "R2 R8 word falls through without read", empty_or_o, 1);
    chk(rd_data_o == DW'(300), "R8 presented data", rd_data_o, 300);
    chk(echo_ren_o == 0, "R9 no echo on fall-through", echo_ren_o, 0);
    write_burst(2, 301);
    fw_read(1'b1);
    fw_read(1'b1);
    fw_read(1'b0);
    chk(empty_or_o == 0, "R8 not ready after last read", empty_or_o, 0);
    hold = rd_data_o;
    rd_en_i = 1'b1; step(1); rd_en_i = 1'b0;
    chk(echo_ren_o == 0, "R10 fall-through read when empty", echo_ren_o, 0);
    chk(rd_data_o == hold, "R10 data kept on empty read", rd_data_o, hold);

    write_burst(1023, 400);
    chk(almost_empty_o == 1, "R11 count 1023 includes presented word", almost_empty_o, 1);
    chk(almost_full_o == 0, "R3 R6 free 1025 above 1023", almost_full_o, 0);
    write_burst(1, 0);
    chk(almost_empty_o == 0, "R11 count 1024", almost_empty_o, 0);
    write_burst(1, 1);
    chk(almost_full_o == 1, "R3 R6 free 1023 at default", almost_full_o, 1);
    chk(full_ir_o == 1, "R8 input-ready while space left", full_ir_o, 1);
    write_burst(DEPTH - 1025, 2);
    chk(full_ir_o == 0, "R8 input-ready low when full", full_ir_o, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule